// File: doc/BRIEF.md
# Speculative Separable Switch Allocator

This block decides, every clock cycle, which virtual channel (VC) of each router input port may send one flit through the crossbar, and which input each output port listens to. Each VC offers at most one request, naming one output port. A request is either non-speculative, meaning the VC already owns a downstream VC, or speculative, meaning its head flit is still waiting for VC allocation. The two classes are handled by two separable allocators that work side by side in the same cycle. Each allocator has a round-robin VC arbiter per input and a round-robin input arbiter per output.

The two results are merged so that a non-speculative winner always comes first. A speculative winner is dropped when its input or its output is already taken by a non-speculative winner. A speculative winner that survives becomes a real crossbar passage only if the same VC also wins VC allocation in that cycle. That outcome arrives on `va_win`. If it does not win, the slot stays empty. Grants depend only on the current inputs. The only state is the arbiter priority pointers, and a pointer moves only when its grant was actually used. A VC without a credit for its downstream VC is masked off and never competes.

Request vectors are flat. Bit `i*V+v` belongs to VC `v` of input `i`. Its output-port field is `req_port[(i*V+v)*PW +: PW]`, where `PW = clog2(P)`. There is no back-pressure: a request that is not granted is simply offered again in a later cycle.

Top module: `ssa_switch_alloc`

## Requirements
- R1: With no credited request present, all `gnt_vld` and `xbar_vld` bits are 0 in the same cycle.
- R2: Among the competing VCs of one input, a round-robin VC arbiter picks the bidder. After a used grant to VC `v`, VC `v+1` (modulo V) has the highest priority.
- R3: Among the inputs whose bidders target one output, a round-robin input arbiter picks the winner. After a used grant to input `i`, input `i+1` (modulo P) has the highest priority.
- R4: A speculative request never wins an output that a non-speculative winner takes in the same cycle.
- R5: A speculative request never wins on an input that holds a non-speculative grant in the same cycle.
- R6: A speculative grant appears on the outputs only if `va_win` is set for that same VC. Otherwise its input and output stay idle for that cycle.
- R7: An arbiter pointer does not move when its grant goes unused, for example a speculative winner that fails VC allocation.
- R8: A request whose `vc_credit` bit is 0 is ignored, and another VC of the same input may win instead.
- R9: Each output carries at most one input, and each input at most one grant. `xbar_vld[o]` with `xbar_sel[o]==i` holds exactly when `gnt_vld[i]` holds with `gnt_port[i]==o`.
- R10: Non-speculative requests are granted regardless of `va_win`.
- R11: The port fields use the encodings stated above. `gnt_vc` field `i` (VW bits, where VW = clog2(V) and at least 1) carries the winning VC, and `gnt_port`/`xbar_sel` fields (PW bits) carry port numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the arbiter pointers |
| req_vld | input | P*V | Request present per VC, index i*V+v |
| req_spec | input | P*V | 1 = speculative request, 0 = non-speculative |
| req_port | input | P*V*PW | Requested output port per VC |
| vc_credit | input | P*V | 1 = downstream credit available for that VC |
| va_win | input | P*V | VC allocation succeeded this cycle for that VC |
| gnt_vld | output | P | Input i sends a flit this cycle |
| gnt_vc | output | P*VW | Winning VC of input i |
| gnt_port | output | P*PW | Output port reached by input i |
| xbar_vld | output | P | Output o carries a flit this cycle |
| xbar_sel | output | P*PW | Input driving output o |

## Verification
Every grant and crossbar select is a combinational function of the request inputs in the same cycle. The bench therefore drives a request pattern just after a falling edge and samples all outputs one nanosecond later, before the next rising edge. The only delayed effect is the move of the arbiter pointers, which happens at the rising edge after a used grant. Pointer-dependent expectations (R2, R3, R7) are checked by repeating or extending the request pattern in the following cycle and observing which VC or input wins there.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
  localparam int unsigned SSA_PORTS = 4;
  localparam int unsigned SSA_VCS   = 2;

  // Width of an index into n items, never zero.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ssa_rr_arb.sv
module ssa_rr_arb #(
  parameter int unsigned N = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [N-1:0]                      req,
  input  logic                              adv,
  output logic [N-1:0]                      gnt,
  output logic [ssa_pkg::idx_w(N)-1:0]      gnt_idx,
  output logic                              any
);
  localparam int unsigned IW = ssa_pkg::idx_w(N);

  logic [IW-1:0] ptr_q;

  // Search from the pointer upward, wrapping once.
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int k = 0; k < int'(N); k++) begin
      int t;
      t = int'(ptr_q) + k;
      if (t >= int'(N)) t = t - int'(N);
      if (!any && req[t]) begin
        any     = 1'b1;
        gnt[t]  = 1'b1;
        gnt_idx = IW'(t);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (adv && any) begin
      ptr_q <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + IW'(1);
    end
  end
endmodule

// File: rtl/ssa_sep_alloc.sv
module ssa_sep_alloc #(
  parameter int unsigned P = 4,
  parameter int unsigned V = 2,
  localparam int unsigned PW = ssa_pkg::idx_w(P),
  localparam int unsigned VW = ssa_pkg::idx_w(V)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [P*V-1:0]    req,
  input  logic [P*V*PW-1:0] port,
  input  logic [P-1:0]      adv_in,
  input  logic [P-1:0]      adv_out,
  output logic [P-1:0]      in_gnt,
  output logic [P*VW-1:0]   in_vc,
  output logic [P*PW-1:0]   in_port,
  output logic [P-1:0]      out_gnt,
  output logic [P*PW-1:0]   out_sel
);
  logic          s1_any  [P];
  logic [VW-1:0] s1_idx  [P];
  logic [PW-1:0] s1_port [P];
  logic [P-1:0]  s2_gnt  [P];

  // Stage one: one VC arbiter per input port.
  for (genvar i = 0; i < P; i++) begin : g_in
    logic [V-1:0] s1_gnt;
    ssa_rr_arb #(.N(V)) u_vc_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req[i*V +: V]),
      .adv     (adv_in[i]),
      .gnt     (s1_gnt),
      .gnt_idx (s1_idx[i]),
      .any     (s1_any[i])
    );
    assign s1_port[i]           = port[(i*V + int'(s1_idx[i]))*PW +: PW];
    assign in_vc[i*VW +: VW]    = s1_idx[i];
    assign in_port[i*PW +: PW]  = s1_port[i];
  end

  // Stage two: one input arbiter per output port.
  for (genvar o = 0; o < P; o++) begin : g_out
    logic [P-1:0]  s2_req;
    logic [PW-1:0] s2_idx;
    always_comb begin
      for (int i = 0; i < int'(P); i++) begin
        s2_req[i] = s1_any[i] && (s1_port[i] == PW'(o));
      end
    end
    ssa_rr_arb #(.N(P)) u_port_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (s2_req),
      .adv     (adv_out[o]),
      .gnt     (s2_gnt[o]),
      .gnt_idx (s2_idx),
      .any     (out_gnt[o])
    );
    assign out_sel[o*PW +: PW] = s2_idx;
  end

  always_comb begin
    in_gnt = '0;
    for (int o = 0; o < int'(P); o++) begin
      in_gnt = in_gnt | s2_gnt[o];
    end
  end
endmodule

// File: rtl/ssa_merge.sv
module ssa_merge #(
  parameter int unsigned P = 4,
  parameter int unsigned V = 2,
  localparam int unsigned PW = ssa_pkg::idx_w(P),
  localparam int unsigned VW = ssa_pkg::idx_w(V)
) (
  input  logic [P-1:0]    ns_in_gnt,
  input  logic [P*VW-1:0] ns_in_vc,
  input  logic [P*PW-1:0] ns_in_port,
  input  logic [P-1:0]    ns_out_gnt,
  input  logic [P*PW-1:0] ns_out_sel,
  input  logic [P-1:0]    sp_in_gnt,
  input  logic [P*VW-1:0] sp_in_vc,
  input  logic [P*PW-1:0] sp_in_port,
  input  logic [P-1:0]    sp_out_gnt,
  input  logic [P*PW-1:0] sp_out_sel,
  input  logic [P*V-1:0]  va_win,
  output logic [P-1:0]    gnt_vld,
  output logic [P*VW-1:0] gnt_vc,
  output logic [P*PW-1:0] gnt_port,
  output logic [P-1:0]    xbar_vld,
  output logic [P*PW-1:0] xbar_sel,
  output logic [P-1:0]    sp_adv_in,
  output logic [P-1:0]    sp_adv_out
);
  logic [P-1:0] sp_ok;

  // Per input: a speculative winner survives only on a free input, a free
  // output and with a successful VC allocation.
  always_comb begin
    for (int i = 0; i < int'(P); i++) begin
      logic [PW-1:0] sp_p;
      logic [VW-1:0] sp_v;
      sp_p     = sp_in_port[i*PW +: PW];
      sp_v     = sp_in_vc[i*VW +: VW];
      sp_ok[i] = sp_in_gnt[i] && !ns_in_gnt[i] && !ns_out_gnt[sp_p]
                 && va_win[i*int'(V) + int'(sp_v)];
      gnt_vld[i] = ns_in_gnt[i] || sp_ok[i];
      gnt_vc[i*VW +: VW]   = ns_in_gnt[i] ? ns_in_vc[i*VW +: VW]   : sp_v;
      gnt_port[i*PW +: PW] = ns_in_gnt[i] ? ns_in_port[i*PW +: PW] : sp_p;
    end
  end

  // Per output: non-speculative selection first, else a surviving speculative one.
  always_comb begin
    for (int o = 0; o < int'(P); o++) begin
      logic [PW-1:0] s;
      s = sp_out_sel[o*PW +: PW];
      sp_adv_out[o] = !ns_out_gnt[o] && sp_out_gnt[o] && sp_ok[s];
      xbar_vld[o]   = ns_out_gnt[o] || sp_adv_out[o];
      xbar_sel[o*PW +: PW] = ns_out_gnt[o] ? ns_out_sel[o*PW +: PW]
                           : (sp_adv_out[o] ? s : '0);
    end
  end

  assign sp_adv_in = sp_ok;
endmodule

// File: rtl/ssa_switch_alloc.sv
module ssa_switch_alloc #(
  parameter int unsigned P = ssa_pkg::SSA_PORTS,
  parameter int unsigned V = ssa_pkg::SSA_VCS,
  localparam int unsigned PW = ssa_pkg::idx_w(P),
  localparam int unsigned VW = ssa_pkg::idx_w(V)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [P*V-1:0]    req_vld,
  input  logic [P*V-1:0]    req_spec,
  input  logic [P*V*PW-1:0] req_port,
  input  logic [P*V-1:0]    vc_credit,
  input  logic [P*V-1:0]    va_win,
  output logic [P-1:0]      gnt_vld,
  output logic [P*VW-1:0]   gnt_vc,
  output logic [P*PW-1:0]   gnt_port,
  output logic [P-1:0]      xbar_vld,
  output logic [P*PW-1:0]   xbar_sel
);
  logic [P*V-1:0] live_req, ns_req, sp_req;

  // Uncredited VCs never compete; the class bit splits the rest.
  assign live_req = req_vld & vc_credit;
  assign ns_req   = live_req & ~req_spec;
  assign sp_req   = live_req &  req_spec;

  logic [P-1:0]    ns_in_gnt, ns_out_gnt, sp_in_gnt, sp_out_gnt;
  logic [P*VW-1:0] ns_in_vc, sp_in_vc;
  logic [P*PW-1:0] ns_in_port, ns_out_sel, sp_in_port, sp_out_sel;
  logic [P-1:0]    sp_adv_in, sp_adv_out;

  ssa_sep_alloc #(.P(P), .V(V)) u_ns_alloc (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (ns_req),
    .port    (req_port),
    .adv_in  (ns_in_gnt),
    .adv_out (ns_out_gnt),
    .in_gnt  (ns_in_gnt),
    .in_vc   (ns_in_vc),
    .in_port (ns_in_port),
    .out_gnt (ns_out_gnt),
    .out_sel (ns_out_sel)
  );

  ssa_sep_alloc #(.P(P), .V(V)) u_sp_alloc (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (sp_req),
    .port    (req_port),
    .adv_in  (sp_adv_in),
    .adv_out (sp_adv_out),
    .in_gnt  (sp_in_gnt),
    .in_vc   (sp_in_vc),
    .in_port (sp_in_port),
    .out_gnt (sp_out_gnt),
    .out_sel (sp_out_sel)
  );

  ssa_merge #(.P(P), .V(V)) u_merge (
    .ns_in_gnt  (ns_in_gnt),
    .ns_in_vc   (ns_in_vc),
    .ns_in_port (ns_in_port),
    .ns_out_gnt (ns_out_gnt),
    .ns_out_sel (ns_out_sel),
    .sp_in_gnt  (sp_in_gnt),
    .sp_in_vc   (sp_in_vc),
    .sp_in_port (sp_in_port),
    .sp_out_gnt (sp_out_gnt),
    .sp_out_sel (sp_out_sel),
    .va_win     (va_win),
    .gnt_vld    (gnt_vld),
    .gnt_vc     (gnt_vc),
    .gnt_port   (gnt_port),
    .xbar_vld   (xbar_vld),
    .xbar_sel   (xbar_sel),
    .sp_adv_in  (sp_adv_in),
    .sp_adv_out (sp_adv_out)
  );
endmodule

// File: rtl/ssa_checker.sv
module ssa_checker #(
  parameter int unsigned P = 4,
  parameter int unsigned V = 2,
  localparam int unsigned PW = ssa_pkg::idx_w(P),
  localparam int unsigned VW = ssa_pkg::idx_w(V)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [P*V-1:0]    req_vld,
  input logic [P*V-1:0]    req_spec,
  input logic [P*V*PW-1:0] req_port,
  input logic [P*V-1:0]    vc_credit,
  input logic [P*V-1:0]    va_win,
  input logic [P-1:0]      gnt_vld,
  input logic [P*VW-1:0]   gnt_vc,
  input logic [P*PW-1:0]   gnt_port,
  input logic [P-1:0]      xbar_vld,
  input logic [P*PW-1:0]   xbar_sel
);
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_vld & vc_credit) == '0) |-> (gnt_vld == '0 && xbar_vld == '0))
    else $error("idle cycle produced a grant"); // R1

  for (genvar i = 0; i < P; i++) begin : g_in_chk
    logic [VW-1:0] g_vc;
    logic [PW-1:0] g_pt;
    assign g_vc = gnt_vc[i*VW +: VW];
    assign g_pt = gnt_port[i*PW +: PW];

    AST_GRANT_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld[i] |-> (req_vld[i*V + int'(g_vc)] && vc_credit[i*V + int'(g_vc)]
                      && req_port[(i*V + int'(g_vc))*PW +: PW] == g_pt))
      else $error("grant without a credited matching request"); // R8

    AST_SPEC_NEEDS_VA: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_vld[i] && req_spec[i*V + int'(g_vc)]) |-> va_win[i*V + int'(g_vc)])
      else $error("speculative grant without VC allocation"); // R6

    AST_GRANT_ON_XBAR: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld[i] |-> (xbar_vld[g_pt] && xbar_sel[int'(g_pt)*PW +: PW] == PW'(i)))
      else $error("granted input missing from crossbar"); // R9
  end

  for (genvar o = 0; o < P; o++) begin : g_out_chk
    logic [PW-1:0] s;
    logic [P-1:0]  hits;
    assign s = xbar_sel[o*PW +: PW];
    always_comb begin
      for (int i = 0; i < int'(P); i++) begin
        hits[i] = gnt_vld[i] && (gnt_port[i*PW +: PW] == PW'(o));
      end
    end

    AST_XBAR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      xbar_vld[o] |-> (gnt_vld[s] && gnt_port[int'(s)*PW +: PW] == PW'(o)))
      else $error("crossbar select disagrees with grant"); // R9

    AST_OUT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hits) <= 1)
      else $error("two inputs granted one output"); // R9
  end
endmodule

bind ssa_switch_alloc ssa_checker #(.P(P), .V(V)) u_ssa_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vld   (req_vld),
  .req_spec  (req_spec),
  .req_port  (req_port),
  .vc_credit (vc_credit),
  .va_win    (va_win),
  .gnt_vld   (gnt_vld),
  .gnt_vc    (gnt_vc),
  .gnt_port  (gnt_port),
  .xbar_vld  (xbar_vld),
  .xbar_sel  (xbar_sel)
);

// File: tb/tb_ssa_switch_alloc.sv
`timescale 1ns/1ps
module tb_ssa_switch_alloc;
  localparam int P  = 4;
  localparam int V  = 2;
  localparam int PW = 2;
  localparam int VW = 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [P*V-1:0]    req_vld, req_spec, vc_credit, va_win;
  logic [P*V*PW-1:0] req_port;
  logic [P-1:0]      gnt_vld, xbar_vld;
  logic [P*VW-1:0]   gnt_vc;
  logic [P*PW-1:0]   gnt_port, xbar_sel;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ssa_switch_alloc dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_spec(req_spec),
    .req_port(req_port), .vc_credit(vc_credit), .va_win(va_win),
    .gnt_vld(gnt_vld), .gnt_vc(gnt_vc), .gnt_port(gnt_port),
    .xbar_vld(xbar_vld), .xbar_sel(xbar_sel)
  );

  task automatic clear_all();
    req_vld = '0; req_spec = '0; req_port = '0; va_win = '0; vc_credit = '1;
  endtask

  task automatic put(input int i, input int v, input bit spec, input int pt, input bit va);
    req_vld[i*V+v]             = 1'b1;
    req_spec[i*V+v]            = spec;
    req_port[(i*V+v)*PW +: PW] = PW'(pt);
    va_win[i*V+v]              = va;
  endtask

  // Drive after the falling edge, sample 1 ns later (outputs are combinational).
  task automatic start_cycle();
    @(negedge clk);
    clear_all();
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic chk_in(input string tag, input int i, input bit vld, input int vc, input int pt);
    n_run++;
    if (gnt_vld[i] !== vld ||
        (vld && (int'(gnt_vc[i*VW +: VW]) != vc || int'(gnt_port[i*PW +: PW]) != pt))) begin
      n_fail++;
      $display("FAIL %s input %0d: got vld=%0b vc=%0d port=%0d, expected vld=%0b vc=%0d port=%0d",
               tag, i, gnt_vld[i], gnt_vc[i*VW +: VW], gnt_port[i*PW +: PW], vld, vc, pt);
    end
  endtask

  task automatic chk_out(input string tag, input int o, input bit vld, input int sel);
    n_run++;
    if (xbar_vld[o] !== vld || (vld && int'(xbar_sel[o*PW +: PW]) != sel)) begin
      n_fail++;
      $display("FAIL %s output %0d: got vld=%0b sel=%0d, expected vld=%0b sel=%0d",
               tag, o, xbar_vld[o], xbar_sel[o*PW +: PW], vld, sel);
    end
  endtask

  task automatic chk_idle(input string tag);
    n_run++;
    if (gnt_vld !== '0 || xbar_vld !== '0) begin
      n_fail++;
      $display("FAIL %s: got gnt_vld=%b xbar_vld=%b, expected 0000 0000", tag, gnt_vld, xbar_vld);
    end
  endtask

  task automatic t_idle();   // R1
    start_cycle(); settle();
    chk_idle("R1 idle after reset");
  endtask

  task automatic t_single_ns();   // R10, R11: va_win low on a non-speculative request
    start_cycle(); put(1, 1, 0, 3, 0); settle();
    chk_in("R10 lone non-spec", 1, 1, 1, 3);
    chk_out("R11 xbar of lone non-spec", 3, 1, 1);
  endtask

  task automatic t_output_rr();   // R3
    start_cycle(); put(0, 0, 0, 0, 0); put(2, 0, 0, 0, 0); settle();
    chk_in("R3 first winner", 0, 1, 0, 0);
    chk_in("R3 first loser", 2, 0, 0, 0);
    chk_out("R3 first select", 0, 1, 0);
    start_cycle(); put(0, 0, 0, 0, 0); put(2, 0, 0, 0, 0); settle();
    chk_in("R3 rotated winner", 2, 1, 0, 0);
    chk_in("R3 rotated loser", 0, 0, 0, 0);
    chk_out("R3 rotated select", 0, 1, 2);
  endtask

  task automatic t_vc_rr();   // R2
    start_cycle(); put(3, 0, 0, 1, 0); put(3, 1, 0, 2, 0); settle();
    chk_in("R2 first VC", 3, 1, 0, 1);
    chk_out("R2 first port", 1, 1, 3);
    start_cycle(); put(3, 0, 0, 1, 0); put(3, 1, 0, 2, 0); settle();
    chk_in("R2 next VC", 3, 1, 1, 2);
    chk_out("R2 next port", 2, 1, 3);
    chk_out("R2 old port idle", 1, 0, 0);
  endtask

  task automatic t_prio_output();   // R4
    start_cycle(); put(0, 1, 1, 2, 1); put(1, 0, 0, 2, 0); settle();
    chk_in("R4 non-spec wins output", 1, 1, 0, 2);
    chk_in("R4 spec blocked", 0, 0, 0, 0);
    chk_out("R4 output select", 2, 1, 1);
  endtask

  task automatic t_prio_input();   // R5
    start_cycle(); put(2, 0, 0, 0, 0); put(2, 1, 1, 1, 1); settle();
    chk_in("R5 input keeps non-spec", 2, 1, 0, 0);
    chk_out("R5 spec output idle", 1, 0, 0);
    chk_out("R5 non-spec output", 0, 1, 2);
  endtask

  task automatic t_spec_ok();   // R6
    start_cycle(); put(0, 1, 1, 3, 1); settle();
    chk_in("R6 spec with VC win", 0, 1, 1, 3);
    chk_out("R6 spec crossbar", 3, 1, 0);
  endtask

  task automatic t_spec_fail();   // R6, R7
    start_cycle(); put(1, 0, 1, 0, 0); settle();
    chk_idle("R6 spec without VC win leaves slot idle");
    start_cycle(); put(1, 0, 1, 0, 1); put(1, 1, 1, 1, 1); settle();
    chk_in("R7 pointer held after unused grant", 1, 1, 0, 0);
    chk_out("R7 output after unused grant", 0, 1, 1);
  endtask

  task automatic t_credit();   // R8
    start_cycle(); put(3, 0, 0, 1, 0); vc_credit[6] = 1'b0; settle();
    chk_idle("R8 uncredited request ignored");
    start_cycle(); put(3, 0, 0, 1, 0); put(3, 1, 0, 2, 0); vc_credit[6] = 1'b0; settle();
    chk_in("R8 credited VC wins", 3, 1, 1, 2);
    chk_out("R8 masked port idle", 1, 0, 0);
  endtask

  task automatic t_mix();   // R4, R5 negative: disjoint classes both pass
    start_cycle(); put(0, 0, 0, 1, 0); put(2, 0, 1, 2, 1); settle();
    chk_in("R4 non-spec beside spec", 0, 1, 0, 1);
    chk_in("R5 spec on free input/output", 2, 1, 0, 2);
    chk_out("R9 out1", 1, 1, 0);
    chk_out("R9 out2", 2, 1, 2);
  endtask

  task automatic t_perm();   // R9
    start_cycle();
    for (int i = 0; i < P; i++) put(i, 0, 0, (i + 1) % P, 0);
    settle();
    for (int i = 0; i < P; i++) chk_in("R9 permutation input", i, 1, 0, (i + 1) % P);
    for (int o = 0; o < P; o++) chk_out("R9 permutation output", o, 1, (o + P - 1) % P);
  endtask

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_idle();
    t_single_ns();
    t_output_rr();
    t_vc_rr();
    t_prio_output();
    t_prio_input();
    t_spec_ok();
    t_spec_fail();
    t_credit();
    t_mix();
    t_perm();
    start_cycle(); settle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule